// File: doc/BRIEF.md
# Speculative Cache Line State Tracker

This block keeps the speculation bookkeeping for a small direct-mapped private cache that runs speculative threads on top of an invalidation-based coherence protocol. For every line it holds a tag, a coherence state, a committed-dirty flag and two speculation marks. The first mark records that a speculative read touched the line. The second records that a speculative write changed it. Local load and store requests arrive on a valid/ready port. Incoming invalidations carry the thread number of the epoch that sent them. Commit and squash are single-cycle pulses. Data storage, the interconnect, the directory and epoch allocation live elsewhere. A request address is `{tag, index}`, with the index in the low bits.

A remote invalidation that hits a line the local thread has speculatively read, and that comes from an epoch ordered before the local one, reports a dependence violation. The order is taken from a per-thread "logically later" mask, so the block never compares full epoch numbers. A line carrying speculation marks may not be evicted, so a conflicting request is held back. The first speculative write to a line held only in shared state records the line address in an ownership-required buffer. On commit those addresses go out in arrival order as ownership requests on a second valid/ready port. On squash they are discarded. Commit turns speculative-exclusive lines into exclusive and speculative-shared lines into shared, and sets the dirty flag of each written line. Squash invalidates the written lines and reverts the rest. Both pulses clear every mark.

Back-pressure: `req_ready` is combinational from the current inputs and state. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A requester that sees `req_ready` low keeps its request, or withdraws it without effect. `own_valid` and `own_addr` hold steady until a cycle with `own_ready` high.

Top module: `spec_line_tracker`

## Requirements
- R1: A load or store accepted at an index marks the line as speculative, so a later request with a different tag at that index raises `repl_stall`, drops `req_ready` and is not accepted.
- R2: An invalidation whose address hits a present line with its speculative-read mark set raises `violation` for exactly the next cycle, when its thread number `t` has `later_mask[t]` = 0 and `t` differs from `own_tid`.
- R3: No violation is raised when the invalidating thread has `later_mask[t]` = 1, when `t` equals `own_tid`, when the tag does not match the stored line, or when the line has only its speculative-write mark set.
- R4: The first accepted speculative store to a line in shared state appends the line address to the ownership-required buffer. A further store to the same line appends nothing, even while the buffer is full.
- R5: When the buffer holds ORB_DEPTH entries and a store would add one more, `orb_stall` is high and `req_ready` is low. That store is not accepted and no entry is dropped.
- R6: After a commit, lines carry no speculation marks. Requests with a different tag at their index are accepted, and invalidations of them report no violation.
- R7: One cycle after a commit with a non-empty buffer, `own_valid` rises and `own_addr` presents the buffered addresses oldest first. Each address is held until a cycle with `own_ready` high, and `own_valid` falls after the last one.
- R8: A squash empties the buffer without issuing anything: a following commit raises no `own_valid`. The squash also clears all speculation marks.
- R9: When squash and an invalidation that would otherwise violate arrive in the same cycle, no violation is reported.
- R10: After reset `req_ready` is high, and `repl_stall`, `orb_stall`, `violation` and `own_valid` are low.
- R11: In a cycle where commit or squash is high, `req_ready` is low.
- R12: While committed ownership requests are still being handed out, a store that would add a buffer entry raises `orb_stall` and is not accepted. Loads are still accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Local request can be taken this cycle |
| req_store | input | 1 | 1 = speculative store, 0 = speculative load |
| req_addr | input | ADDR_W | Request line address {tag, index} |
| inv_valid | input | 1 | Incoming invalidation message |
| inv_addr | input | ADDR_W | Invalidated line address {tag, index} |
| inv_tid | input | TID_W | Thread number of the invalidating epoch |
| own_tid | input | TID_W | Thread number of the local epoch |
| later_mask | input | 2**TID_W | Bit t set: thread t is logically later than the local epoch |
| commit | input | 1 | Commit pulse (speculation succeeded) |
| squash | input | 1 | Squash pulse (speculation discarded) |
| violation | output | 1 | One-cycle dependence violation report |
| repl_stall | output | 1 | Request blocked by a speculative line at its index |
| orb_stall | output | 1 | Store blocked because the ownership buffer cannot take it |
| own_valid | output | 1 | Ownership request available |
| own_ready | input | 1 | Ownership request consumer accepts |
| own_addr | output | ADDR_W | Line address needing exclusive ownership |

## Verification
The properties take for granted that commit and squash are never raised in the same cycle, and that `own_tid` and `later_mask` hold steady across a speculative epoch. The stimulus raises each pulse alone and programs the thread ordering once. It changes inputs only half a cycle away from the sampling edge, and withdraws a stalled request after one cycle instead of changing its address while it waits. The drain checks hold `own_ready` low for several cycles so that the hold-steady property sees back-pressure.

// File: rtl/spec_track_pkg.sv
package spec_track_pkg;

  typedef enum logic [2:0] {
    LS_INV = 3'd0,
    LS_SHR = 3'd1,
    LS_EXC = 3'd2,
    LS_SPS = 3'd3,
    LS_SPE = 3'd4
  } line_st_e;

  typedef struct packed {
    line_st_e st;
    logic     rd_mark;
    logic     wr_mark;
    logic     dirty;
  } line_t;

  function automatic line_st_e commit_state(input line_st_e s);
    case (s)
      LS_SPS:  return LS_SHR;
      LS_SPE:  return LS_EXC;
      default: return s;
    endcase
  endfunction

  function automatic logic is_shared(input line_st_e s);
    return (s == LS_SHR) || (s == LS_SPS);
  endfunction

endpackage

// File: rtl/spec_line_array.sv
module spec_line_array
  import spec_track_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int TAG_W     = 4,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_store,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [TAG_W-1:0] acc_tag,
  input  logic             inv_valid,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic             commit,
  input  logic             squash,
  output logic             req_present,
  output logic             req_tag_match,
  output logic             req_spec,
  output logic             req_shared,
  output logic             req_wr_mark,
  output logic             inv_hit_rd
);

  logic [TAG_W-1:0] tag_q  [NUM_LINES];
  line_t            line_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [TAG_W-1:0] tag_n;
    line_t            line_n;
    logic             acc_hit;
    logic             inv_hit;

    assign acc_hit = (line_q[g].st != LS_INV) && (tag_q[g] == acc_tag);
    assign inv_hit = inv_valid && (inv_idx == IDX_W'(g)) &&
                     (line_q[g].st != LS_INV) && (tag_q[g] == inv_tag);

    always_comb begin
      tag_n  = tag_q[g];
      line_n = line_q[g];
      if (commit) begin
        line_n.st      = commit_state(line_q[g].st);
        line_n.dirty   = line_q[g].dirty | line_q[g].wr_mark;
        line_n.rd_mark = 1'b0;
        line_n.wr_mark = 1'b0;
      end else if (squash) begin
        if (line_q[g].wr_mark) begin
          line_n = '{st: LS_INV, rd_mark: 1'b0, wr_mark: 1'b0, dirty: 1'b0};
        end else begin
          line_n.st      = commit_state(line_q[g].st);
          line_n.rd_mark = 1'b0;
        end
      end else if (acc_en && (acc_idx == IDX_W'(g))) begin
        if (acc_hit) begin
          if (acc_store) begin
            line_n.st      = is_shared(line_q[g].st) ? LS_SPS : LS_SPE;
            line_n.wr_mark = 1'b1;
          end else begin
            line_n.st      = is_shared(line_q[g].st) ? LS_SPS : LS_SPE;
            line_n.rd_mark = 1'b1;
          end
        end else begin
          tag_n = acc_tag;
          if (acc_store) begin
            line_n = '{st: LS_SPE, rd_mark: 1'b0, wr_mark: 1'b1, dirty: 1'b0};
          end else begin
            line_n = '{st: LS_SPS, rd_mark: 1'b1, wr_mark: 1'b0, dirty: 1'b0};
          end
        end
      end
      // coherence invalidation is always honoured, after any local update
      if (inv_hit) begin
        line_n = '{st: LS_INV, rd_mark: 1'b0, wr_mark: 1'b0, dirty: 1'b0};
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[g]  <= '0;
        line_q[g] <= '{st: LS_INV, rd_mark: 1'b0, wr_mark: 1'b0, dirty: 1'b0};
      end else begin
        tag_q[g]  <= tag_n;
        line_q[g] <= line_n;
      end
    end
  end

  always_comb begin
    req_present   = line_q[acc_idx].st != LS_INV;
    req_tag_match = tag_q[acc_idx] == acc_tag;
    req_spec      = line_q[acc_idx].rd_mark | line_q[acc_idx].wr_mark;
    req_shared    = is_shared(line_q[acc_idx].st);
    req_wr_mark   = line_q[acc_idx].wr_mark;
    inv_hit_rd    = inv_valid && (line_q[inv_idx].st != LS_INV) &&
                    (tag_q[inv_idx] == inv_tag) && line_q[inv_idx].rd_mark;
  end

endmodule

// File: rtl/spec_orb.sv
module spec_orb #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 7,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              commit,
  input  logic              squash,
  output logic              full,
  output logic              draining,
  output logic              own_valid,
  input  logic              own_ready,
  output logic [ADDR_W-1:0] own_addr
);

  logic [ADDR_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              drain_q;

  assign full      = cnt_q == CNT_W'(DEPTH);
  assign draining  = drain_q;
  assign own_valid = drain_q;
  assign own_addr  = mem_q[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      drain_q  <= 1'b0;
    end else if (drain_q) begin
      if (own_ready) begin
        if (cnt_q == CNT_W'(1)) begin
          drain_q  <= 1'b0;
          cnt_q    <= '0;
          wr_ptr_q <= '0;
          rd_ptr_q <= '0;
        end else begin
          cnt_q    <= cnt_q - CNT_W'(1);
          rd_ptr_q <= PTR_W'(rd_ptr_q + PTR_W'(1));
        end
      end
    end else if (squash) begin
      cnt_q    <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (commit) begin
      drain_q <= cnt_q != '0;
    end else if (push && !full) begin
      wr_ptr_q <= PTR_W'(wr_ptr_q + PTR_W'(1));
      cnt_q    <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !drain_q && !commit && !squash) begin
      mem_q[wr_ptr_q] <= push_addr;
    end
  end

endmodule

// File: rtl/spec_line_tracker.sv
module spec_line_tracker #(
  parameter int NUM_LINES = 8,
  parameter int TAG_W     = 4,
  parameter int TID_W     = 2,
  parameter int ORB_DEPTH = 4,
  localparam int IDX_W       = $clog2(NUM_LINES),
  localparam int ADDR_W      = TAG_W + IDX_W,
  localparam int NUM_THREADS = 1 << TID_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_store,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   inv_valid,
  input  logic [ADDR_W-1:0]      inv_addr,
  input  logic [TID_W-1:0]       inv_tid,
  input  logic [TID_W-1:0]       own_tid,
  input  logic [NUM_THREADS-1:0] later_mask,
  input  logic                   commit,
  input  logic                   squash,
  output logic                   violation,
  output logic                   repl_stall,
  output logic                   orb_stall,
  output logic                   own_valid,
  input  logic                   own_ready,
  output logic [ADDR_W-1:0]      own_addr
);

  logic req_present, req_tag_match, req_spec, req_shared, req_wr_mark;
  logic inv_hit_rd;
  logic orb_full, orb_draining;
  logic needs_orb, accept, inv_earlier, violation_q;

  assign needs_orb  = req_valid && req_store && req_present && req_tag_match &&
                      req_shared && !req_wr_mark;
  assign repl_stall = req_valid && req_present && !req_tag_match && req_spec;
  assign orb_stall  = needs_orb && (orb_full || orb_draining);
  assign req_ready  = !(commit || squash || repl_stall || orb_stall);
  assign accept     = req_valid && req_ready;

  assign inv_earlier = !later_mask[inv_tid] && (inv_tid != own_tid);

  spec_line_array #(
    .NUM_LINES (NUM_LINES),
    .TAG_W     (TAG_W)
  ) u_lines (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_en        (accept),
    .acc_store     (req_store),
    .acc_idx       (req_addr[IDX_W-1:0]),
    .acc_tag       (req_addr[ADDR_W-1:IDX_W]),
    .inv_valid     (inv_valid),
    .inv_idx       (inv_addr[IDX_W-1:0]),
    .inv_tag       (inv_addr[ADDR_W-1:IDX_W]),
    .commit        (commit),
    .squash        (squash),
    .req_present   (req_present),
    .req_tag_match (req_tag_match),
    .req_spec      (req_spec),
    .req_shared    (req_shared),
    .req_wr_mark   (req_wr_mark),
    .inv_hit_rd    (inv_hit_rd)
  );

  spec_orb #(
    .DEPTH  (ORB_DEPTH),
    .ADDR_W (ADDR_W)
  ) u_orb (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept && needs_orb),
    .push_addr (req_addr),
    .commit    (commit),
    .squash    (squash),
    .full      (orb_full),
    .draining  (orb_draining),
    .own_valid (own_valid),
    .own_ready (own_ready),
    .own_addr  (own_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      violation_q <= 1'b0;
    end else begin
      violation_q <= inv_hit_rd && inv_earlier && !squash && !commit;
    end
  end

  assign violation = violation_q;

endmodule

// File: rtl/spec_line_tracker_chk.sv
module spec_line_tracker_chk #(
  parameter int TID_W  = 2,
  parameter int ADDR_W = 7,
  localparam int NUM_THREADS = 1 << TID_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_store,
  input logic                   inv_valid,
  input logic [TID_W-1:0]       inv_tid,
  input logic [TID_W-1:0]       own_tid,
  input logic [NUM_THREADS-1:0] later_mask,
  input logic                   commit,
  input logic                   squash,
  input logic                   violation,
  input logic                   repl_stall,
  input logic                   orb_stall,
  input logic                   own_valid,
  input logic                   own_ready,
  input logic [ADDR_W-1:0]      own_addr
);

  AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> $past(inv_valid && !squash && !commit &&
                        !later_mask[inv_tid] && (inv_tid != own_tid))); // R2

  AST_SQUASH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !violation); // R9

  AST_OWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (own_valid && !own_ready) |=> (own_valid && $stable(own_addr))); // R7

  AST_OWN_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_valid) |-> $past(commit)); // R7

  AST_ORB_STALL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    orb_stall |-> (req_valid && req_store)); // R5

  AST_REPL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    repl_stall |-> req_valid); // R1

endmodule

bind spec_line_tracker spec_line_tracker_chk #(
  .TID_W  (TID_W),
  .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/spec_line_tracker_tb.sv
module spec_line_tracker_tb;

  localparam int ADDR_W = 7;
  localparam int NV     = 22;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0, req_store = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic             inv_valid = 1'b0;
  logic [ADDR_W-1:0] inv_addr = '0;
  logic [1:0]       inv_tid = '0;
  logic [1:0]       own_tid = 2'd0;
  logic [3:0]       later_mask = 4'b1100;
  logic             commit = 1'b0, squash = 1'b0, own_ready = 1'b0;
  logic             req_ready, violation, repl_stall, orb_stall, own_valid;
  logic [ADDR_W-1:0] own_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spec_line_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_addr(req_addr), .inv_valid(inv_valid),
    .inv_addr(inv_addr), .inv_tid(inv_tid), .own_tid(own_tid),
    .later_mask(later_mask), .commit(commit), .squash(squash),
    .violation(violation), .repl_stall(repl_stall), .orb_stall(orb_stall),
    .own_valid(own_valid), .own_ready(own_ready), .own_addr(own_addr)
  );

  // {kind(0 load,1 store,2 inval), addr, tid, ready, repl, orbst, viol}
  localparam logic [14:0] VEC [NV] = '{
    {2'd0, 7'h08, 2'd0, 4'b1000},  // R1 load installs
    {2'd2, 7'h08, 2'd2, 4'b1000},  // R3 later thread
    {2'd0, 7'h08, 2'd0, 4'b1000},
    {2'd2, 7'h08, 2'd1, 4'b1001},  // R2 earlier thread
    {2'd0, 7'h09, 2'd0, 4'b1000},
    {2'd2, 7'h11, 2'd1, 4'b1000},  // R3 tag mismatch
    {2'd2, 7'h09, 2'd0, 4'b1000},  // R3 own thread
    {2'd1, 7'h0A, 2'd0, 4'b1000},
    {2'd2, 7'h0A, 2'd1, 4'b1000},  // R3 write mark only
    {2'd0, 7'h0B, 2'd0, 4'b1000},
    {2'd0, 7'h1B, 2'd0, 4'b0100},  // R1 replacement stall
    {2'd1, 7'h0B, 2'd0, 4'b1000},  // R4 entry 0
    {2'd0, 7'h0C, 2'd0, 4'b1000},
    {2'd1, 7'h0C, 2'd0, 4'b1000},  // R4 entry 1
    {2'd0, 7'h0D, 2'd0, 4'b1000},
    {2'd1, 7'h0D, 2'd0, 4'b1000},  // R4 entry 2
    {2'd0, 7'h0E, 2'd0, 4'b1000},
    {2'd1, 7'h0E, 2'd0, 4'b1000},  // R4 entry 3
    {2'd0, 7'h0F, 2'd0, 4'b1000},
    {2'd1, 7'h0F, 2'd0, 4'b0010},  // R5 buffer full
    {2'd1, 7'h0B, 2'd0, 4'b1000},  // R4 repeat store, no entry
    {2'd2, 7'h0C, 2'd3, 4'b1000}   // R3 later thread
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; req_store = 1'b0; inv_valid = 1'b0;
    commit = 1'b0; squash = 1'b0;
  endtask

  // drive one request at negedge, check ready now, violation after edge
  task automatic op(input logic [1:0] kind, input logic [6:0] a, input logic [1:0] t,
                    input logic exp_ready, input string req);
    @(negedge clk);
    idle();
    if (kind == 2'd2) begin
      inv_valid = 1'b1; inv_addr = a; inv_tid = t;
    end else begin
      req_valid = 1'b1; req_store = kind[0]; req_addr = a;
    end
    #1 chk(req, req_ready, exp_ready);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10 ready", req_ready, 1);
    chk("R10 repl_stall", repl_stall, 0);
    chk("R10 orb_stall", orb_stall, 0);
    chk("R10 violation", violation, 0);
    chk("R10 own_valid", own_valid, 0);

    for (int i = 0; i < NV; i++) begin
      logic [14:0] v;
      v = VEC[i];
      @(negedge clk);
      idle();
      if (v[14:13] == 2'd2) begin
        inv_valid = 1'b1; inv_addr = v[12:6]; inv_tid = v[5:4];
      end else begin
        req_valid = 1'b1; req_store = v[13]; req_addr = v[12:6];
      end
      #1;
      chk("R1/R5 vector ready", req_ready, v[3]);
      chk("R1 vector repl_stall", repl_stall, v[2]);
      chk("R5 vector orb_stall", orb_stall, v[1]);
      @(posedge clk);
      #1 chk("R2/R3 vector violation", violation, v[0]);
    end

    // R11 commit blocks requests; R7 drain starts next cycle
    @(negedge clk);
    idle();
    commit = 1'b1; req_valid = 1'b1; req_store = 1'b0; req_addr = 7'h1B;
    #1 chk("R11 ready during commit", req_ready, 0);
    @(negedge clk);
    idle();
    #1;
    chk("R7 own_valid after commit", own_valid, 1);
    chk("R7 first addr", own_addr, 7'h0B);

    // R12 new buffer entry stalls while draining
    op(2'd1, 7'h0F, 2'd0, 1'b0, "R12 store during drain");
    chk("R12 orb_stall", orb_stall, 1);
    // R6 replacement allowed after commit; R12 loads proceed
    op(2'd0, 7'h1B, 2'd0, 1'b1, "R6 replace after commit");
    op(2'd2, 7'h0D, 2'd1, 1'b1, "R6 inval after commit");
    @(posedge clk);
    #1 chk("R6 no violation after commit", violation, 0);
    chk("R7 addr held", own_addr, 7'h0B);

    // R7 drain order
    @(negedge clk);
    idle();
    own_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      logic [6:0] e;
      e = 7'h0B + 7'(k);
      #1;
      chk("R7 own_valid", own_valid, 1);
      chk("R7 own_addr order", own_addr, e);
      @(negedge clk);
    end
    #1 chk("R7 own_valid falls", own_valid, 0);
    own_ready = 1'b0;

    // R8 / R9 squash
    op(2'd0, 7'h0F, 2'd0, 1'b1, "R8 load");
    op(2'd1, 7'h1B, 2'd0, 1'b1, "R4 store to shared line");
    @(negedge clk);
    idle();
    squash = 1'b1; inv_valid = 1'b1; inv_addr = 7'h1B; inv_tid = 2'd1;
    #1 chk("R11 ready during squash", req_ready, 0);
    @(posedge clk);
    #1 chk("R9 no violation with squash", violation, 0);
    op(2'd0, 7'h1F, 2'd0, 1'b1, "R8 marks cleared by squash");
    chk("R8 no repl_stall", repl_stall, 0);
    @(negedge clk);
    idle();
    commit = 1'b1;
    @(negedge clk);
    idle();
    #1 chk("R8 buffer emptied by squash", own_valid, 0);
    @(negedge clk);
    #1 chk("R8 still no ownership request", own_valid, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule